// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It is purely combinational: the sequencer presents an operation code, the accumulator value, a second operand (usually the byte fetched from memory) and the current carry, negative, overflow and zero flags. In the same cycle it returns the 8-bit result, the four updated flags and two write strobes that say where the result belongs.

Arithmetic is binary only. Subtraction reuses the adder by feeding it the ones' complement of the operand, so the incoming carry acts as "no borrow". Signed overflow comes from the sign bits of the operands and the result. Compare and bit test change flags but request no write. Shifts, rotates, increment and decrement work on either the accumulator or the memory operand, chosen by a mode input. The same input steers the result to the accumulator or to the memory write-back path.

There is no state and no clock inside the block. The sequencer picks the operation for each cycle, and the block has no modes of its own beyond the source and destination choice.

Top module: `alu8_core`

## Requirements
- R1: `op_sel` encodes 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 compare, 6 bit test, 7 shift left, 8 shift right, 9 rotate left, 10 rotate right, 11 increment, 12 decrement. Codes 13 to 15 return `opnd_a` unchanged, pass all four flags through and assert neither write strobe.
- R2: Add returns A + M + C. Carry out is set when the 9-bit sum exceeds 0xFF. V is set when A and M share a sign bit that differs from the result's sign bit. N is result bit 7, Z is set for a zero result, and `acc_wr` is 1.
- R3: Subtract returns A + ~M + C, with carry out set when no borrow occurred. V uses the add rule on A and ~M. N and Z follow the result, and `acc_wr` is 1.
- R4: AND, OR and XOR of A and M write the accumulator and set N and Z from the result. V and C pass through.
- R5: Compare sets C when A is greater than or equal to M (unsigned), and sets N and Z from the 8-bit difference A - M, which appears on `result`. V passes through and neither strobe is asserted.
- R6: Bit test sets N from M bit 7, V from M bit 6 and Z when A AND M is zero. C passes through and neither strobe is asserted.
- R7: Shift left returns the source shifted up with 0 in bit 0 and moves source bit 7 into C. N and Z follow the result and V passes through.
- R8: Shift right returns the source shifted down with 0 in bit 7 and moves source bit 0 into C. N is always cleared.
- R9: Rotate left puts the incoming C into bit 0 and source bit 7 into C. Rotate right puts the incoming C into bit 7, and therefore into N, and source bit 0 into C. V passes through.
- R10: Increment and decrement return the source plus or minus one, wrapping modulo 256. N and Z follow the result, and C and V pass through.
- R11: For codes 7 to 12, `mem_mode` = 0 takes A as the source and asserts `acc_wr`, while `mem_mode` = 1 takes M and asserts `mem_wr`. `acc_wr` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | Accumulator or register operand |
| opnd_m | input | 8 | Memory or immediate operand |
| mem_mode | input | 1 | Source and destination select for shift, rotate, increment and decrement |
| flag_c_in | input | 1 | Incoming carry |
| flag_n_in | input | 1 | Incoming negative flag |
| flag_v_in | input | 1 | Incoming overflow flag |
| flag_z_in | input | 1 | Incoming zero flag |
| result | output | 8 | Operation result |
| flag_n_out | output | 1 | Updated negative flag |
| flag_v_out | output | 1 | Updated overflow flag |
| flag_z_out | output | 1 | Updated zero flag |
| flag_c_out | output | 1 | Updated carry flag |
| acc_wr | output | 1 | Result is destined for the accumulator |
| mem_wr | output | 1 | Result is destined for memory write-back |

## Verification
The adder is driven at the signed boundaries to separate the cases that matter:
- 0x50 + 0x50 overflows positive to negative.
- 0xFF + 0x01 carries out to zero.
- Mixed-sign subtracts show whether the overflow term uses the inverted operand.

Compare is tried with A below, equal to and above M, to pin down the unsigned carry and to confirm that V is held. Shifts and rotates use 0x81 and 0x01 with carry in both states, so a wrong end bit or a missing carry insert shows up. Increment and decrement run across 0xFF and 0x00 in both modes, checking the wrap, the source choice and the write strobes. A random sweep over all sixteen codes then exercises the reserved codes and mixed flag inputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_CMP = 4'd5,
        OP_BIT = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             invert,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    assign b_eff = invert ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    assign sum   = full[MSB:0];
    assign cout  = full[WIDTH];
    // same-sign inputs producing a different-sign result
    assign ovf   = ~(a[MSB] ^ b_eff[MSB]) & (a[MSB] ^ sum[MSB]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] src,
    input  logic             cin,
    input  logic             left,
    input  logic             rotate,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    logic fill;

    assign fill = rotate & cin;

    always_comb begin
        if (left) begin
            res  = {src[MSB-1:0], fill};
            cout = src[MSB];
        end else begin
            res  = {fill, src[MSB:1]};
            cout = src[0];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        unique case (sel)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = a & b;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_m,
    input  logic             mem_mode,
    input  logic             flag_c_in,
    input  logic             flag_n_in,
    input  logic             flag_v_in,
    input  logic             flag_z_in,
    output logic [WIDTH-1:0] result,
    output logic             flag_n_out,
    output logic             flag_v_out,
    output logic             flag_z_out,
    output logic             flag_c_out,
    output logic             acc_wr,
    output logic             mem_wr
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    alu_op_e          op;
    logic [WIDTH-1:0] src;
    logic             add_inv;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic             sh_left;
    logic             sh_rot;
    logic [WIDTH-1:0] sh_res;
    logic             sh_cout;
    logic_sel_e       lg_sel;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] step_up;
    logic [WIDTH-1:0] step_dn;

    assign op      = alu_op_e'(op_sel);
    assign src     = mem_mode ? opnd_m : opnd_a;
    assign add_inv = (op == OP_SUB) || (op == OP_CMP);
    assign add_cin = (op == OP_CMP) ? 1'b1 : flag_c_in;
    assign sh_left = (op == OP_SHL) || (op == OP_ROL);
    assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);
    assign step_up = src + ONE;
    assign step_dn = src - ONE;

    always_comb begin
        unique case (op)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    alu8_adder #(.WIDTH(WIDTH)) u_adder (
        .a      (opnd_a),
        .b      (opnd_m),
        .cin    (add_cin),
        .invert (add_inv),
        .sum    (add_sum),
        .cout   (add_cout),
        .ovf    (add_ovf)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .src    (src),
        .cin    (flag_c_in),
        .left   (sh_left),
        .rotate (sh_rot),
        .res    (sh_res),
        .cout   (sh_cout)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opnd_a),
        .b   (opnd_m),
        .sel (lg_sel),
        .res (lg_res)
    );

    always_comb begin
        result     = opnd_a;
        flag_n_out = flag_n_in;
        flag_v_out = flag_v_in;
        flag_z_out = flag_z_in;
        flag_c_out = flag_c_in;
        acc_wr     = 1'b0;
        mem_wr     = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result     = add_sum;
                flag_c_out = add_cout;
                flag_v_out = add_ovf;
                flag_n_out = add_sum[MSB];
                flag_z_out = (add_sum == '0);
                acc_wr     = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result     = lg_res;
                flag_n_out = lg_res[MSB];
                flag_z_out = (lg_res == '0);
                acc_wr     = 1'b1;
            end
            OP_CMP: begin
                result     = add_sum;
                flag_c_out = add_cout;
                flag_n_out = add_sum[MSB];
                flag_z_out = (add_sum == '0);
            end
            OP_BIT: begin
                result     = lg_res;
                flag_n_out = opnd_m[MSB];
                flag_v_out = opnd_m[MSB-1];
                flag_z_out = (lg_res == '0);
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                result     = sh_res;
                flag_c_out = sh_cout;
                flag_n_out = sh_res[MSB];
                flag_z_out = (sh_res == '0);
                acc_wr     = ~mem_mode;
                mem_wr     = mem_mode;
            end
            OP_INC, OP_DEC: begin
                result     = (op == OP_INC) ? step_up : step_dn;
                flag_n_out = result[MSB];
                flag_z_out = (result == '0);
                acc_wr     = ~mem_mode;
                mem_wr     = mem_mode;
            end
            default: begin
                result = opnd_a;
            end
        endcase
    end

    always_comb begin
        if (op == OP_ADD) begin
            // R2
            add_sum_chk: assert ({flag_c_out, result} ==
                ({1'b0, opnd_a} + {1'b0, opnd_m} + {{WIDTH{1'b0}}, flag_c_in}));
        end
        if (op == OP_CMP) begin
            // R5
            cmp_v_hold_chk: assert (flag_v_out == flag_v_in && !acc_wr && !mem_wr);
        end
        if (op == OP_SHR) begin
            // R8
            shr_n_clear_chk: assert (!flag_n_out && !result[MSB]);
        end
        if (op == OP_INC || op == OP_DEC) begin
            // R10
            step_c_hold_chk: assert (flag_c_out == flag_c_in && flag_v_out == flag_v_in);
        end
        // R11
        wr_excl_chk: assert (!(acc_wr && mem_wr));
    end
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    typedef struct packed {
        logic [7:0] r;
        logic       n;
        logic       v;
        logic       z;
        logic       c;
        logic       aw;
        logic       mw;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_m = '0;
    logic       mem_mode = 1'b0;
    logic       flag_c_in = 1'b0;
    logic       flag_n_in = 1'b0;
    logic       flag_v_in = 1'b0;
    logic       flag_z_in = 1'b0;
    logic [7:0] result;
    logic       flag_n_out, flag_v_out, flag_z_out, flag_c_out, acc_wr, mem_wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    alu8_core u_dut (
        .op_sel     (op_sel),
        .opnd_a     (opnd_a),
        .opnd_m     (opnd_m),
        .mem_mode   (mem_mode),
        .flag_c_in  (flag_c_in),
        .flag_n_in  (flag_n_in),
        .flag_v_in  (flag_v_in),
        .flag_z_in  (flag_z_in),
        .result     (result),
        .flag_n_out (flag_n_out),
        .flag_v_out (flag_v_out),
        .flag_z_out (flag_z_out),
        .flag_c_out (flag_c_out),
        .acc_wr     (acc_wr),
        .mem_wr     (mem_wr)
    );

    function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                   input logic [7:0] m, input logic md,
                                   input logic c, input logic n,
                                   input logic v, input logic z);
        exp_t       e;
        logic [7:0] s;
        logic [8:0] w;
        s = md ? m : a;
        e = '{r: a, n: n, v: v, z: z, c: c, aw: 1'b0, mw: 1'b0};
        case (op)
            4'd0: begin
                w = 9'(a) + 9'(m) + 9'(c);
                e.r = w[7:0]; e.c = (w > 9'd255);
                e.v = (a[7] == m[7]) && (e.r[7] != a[7]); e.aw = 1'b1;
            end
            4'd1: begin
                w = 9'(a) + 9'(8'hFF - m) + 9'(c);
                e.r = w[7:0]; e.c = (w > 9'd255);
                e.v = (a[7] != m[7]) && (e.r[7] != a[7]); e.aw = 1'b1;
            end
            4'd2: begin e.r = a & m; e.aw = 1'b1; end
            4'd3: begin e.r = a | m; e.aw = 1'b1; end
            4'd4: begin e.r = a ^ m; e.aw = 1'b1; end
            4'd5: begin e.r = a - m; e.c = (a >= m); end
            4'd6: e.r = a & m;
            4'd7: begin e.r = {s[6:0], 1'b0}; e.c = s[7]; end
            4'd8: begin e.r = {1'b0, s[7:1]}; e.c = s[0]; end
            4'd9: begin e.r = {s[6:0], c}; e.c = s[7]; end
            4'd10: begin e.r = {c, s[7:1]}; e.c = s[0]; end
            4'd11: e.r = s + 8'd1;
            4'd12: e.r = s - 8'd1;
            default: ;
        endcase
        if (op <= 4'd5 || (op >= 4'd7 && op <= 4'd12)) begin
            e.n = e.r[7];
            e.z = (e.r == 8'd0);
        end
        if (op == 4'd6) begin
            e.n = m[7]; e.v = m[6]; e.z = ((a & m) == 8'd0);
        end
        if (op >= 4'd7 && op <= 4'd12) begin
            e.aw = ~md; e.mw = md;
        end
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                         input logic md, input logic c, input logic n, input logic v,
                         input logic z, input string tag);
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_m = m; mem_mode = md;
        flag_c_in = c; flag_n_in = n; flag_v_in = v; flag_z_in = z;
        exp_q.push_back(model(op, a, m, md, c, n, v, z));
        tag_q.push_back(tag);
    endtask

    // monitor: compares one queued expectation per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  got;
                string t;
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                got = '{r: result, n: flag_n_out, v: flag_v_out, z: flag_z_out,
                        c: flag_c_out, aw: acc_wr, mw: mem_wr};
                checks++;
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s op=%0d a=%02h m=%02h: got r=%02h nvzc=%b%b%b%b aw=%b mw=%b expected r=%02h nvzc=%b%b%b%b aw=%b mw=%b",
                             t, op_sel, opnd_a, opnd_m, got.r, got.n, got.v, got.z, got.c,
                             got.aw, got.mw, e.r, e.n, e.v, e.z, e.c, e.aw, e.mw);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle inputs: all zero, add
        drive(4'd0, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R2 idle");
        // R2 add corners
        drive(4'd0, 8'h50, 8'h50, 0, 0, 0, 0, 0, "R2 pos overflow");
        drive(4'd0, 8'hFF, 8'h01, 0, 0, 0, 1, 0, "R2 carry to zero");
        drive(4'd0, 8'h10, 8'h20, 0, 1, 1, 0, 1, "R2 carry in");
        drive(4'd0, 8'h80, 8'h80, 0, 0, 0, 0, 0, "R2 neg overflow");
        // R3 subtract
        drive(4'd1, 8'h50, 8'hF0, 0, 1, 0, 0, 0, "R3 borrow");
        drive(4'd1, 8'h50, 8'hB0, 0, 1, 0, 0, 0, "R3 overflow");
        drive(4'd1, 8'h40, 8'h40, 0, 0, 0, 1, 0, "R3 borrow in");
        drive(4'd1, 8'h40, 8'h40, 0, 1, 0, 1, 0, "R3 equal");
        // R4 logic
        drive(4'd2, 8'hF0, 8'h0F, 0, 1, 0, 1, 0, "R4 and zero");
        drive(4'd3, 8'h80, 8'h01, 0, 0, 0, 1, 1, "R4 or");
        drive(4'd4, 8'hAA, 8'hAA, 0, 1, 1, 0, 0, "R4 xor");
        // R5 compare
        drive(4'd5, 8'h10, 8'h20, 0, 1, 0, 1, 0, "R5 less");
        drive(4'd5, 8'h20, 8'h20, 0, 0, 0, 0, 0, "R5 equal");
        drive(4'd5, 8'hF0, 8'h20, 0, 0, 0, 1, 0, "R5 greater");
        // R6 bit test
        drive(4'd6, 8'h01, 8'hC0, 0, 1, 0, 0, 0, "R6 high bits");
        drive(4'd6, 8'h01, 8'h41, 0, 0, 1, 0, 1, "R6 nonzero");
        // R7, R8, R9 shifts and rotates
        drive(4'd7, 8'h81, 8'h00, 0, 0, 0, 1, 0, "R7 shl acc");
        drive(4'd7, 8'h00, 8'h40, 1, 1, 0, 0, 0, "R7 shl mem");
        drive(4'd8, 8'h81, 8'h00, 0, 0, 1, 0, 0, "R8 shr");
        drive(4'd8, 8'h00, 8'h01, 1, 0, 1, 0, 0, "R8 shr zero");
        drive(4'd9, 8'h81, 8'h00, 0, 1, 0, 0, 0, "R9 rol c1");
        drive(4'd9, 8'h01, 8'h00, 0, 0, 0, 0, 0, "R9 rol c0");
        drive(4'd10, 8'h01, 8'h00, 0, 1, 0, 0, 0, "R9 ror c1");
        drive(4'd10, 8'h00, 8'h81, 1, 0, 1, 1, 0, "R9 ror mem");
        // R10, R11 step and destination
        drive(4'd11, 8'hFF, 8'h00, 0, 1, 0, 1, 0, "R10 inc wrap");
        drive(4'd11, 8'h00, 8'h7F, 1, 0, 0, 0, 0, "R11 inc mem");
        drive(4'd12, 8'h00, 8'h55, 0, 0, 0, 0, 0, "R10 dec wrap");
        drive(4'd12, 8'h33, 8'h01, 1, 1, 0, 0, 0, "R11 dec mem");
        // R1 reserved codes
        drive(4'd13, 8'h5A, 8'hFF, 1, 1, 0, 1, 0, "R1 reserved 13");
        drive(4'd15, 8'hA5, 8'h00, 0, 0, 1, 0, 1, "R1 reserved 15");
        // R1 random sweep over all codes
        for (int i = 0; i < 400; i++) begin
            logic [15:0] rv;
            rv = 16'($urandom);
            drive(4'(i % 16), 8'($urandom), 8'($urandom), rv[0], rv[1], rv[2],
                  rv[3], rv[4], "R1 sweep");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule